// File: doc/BRIEF.md
# Auxiliary Table Range Programmer

This block writes or retires entries in a three-level translation structure that links main-surface memory to its auxiliary (compression) data. One command names a range of main-surface addresses. The block walks that range one 64 KB chunk at a time. For each chunk it descends from a root table through a middle table to a leaf table. Every entry is a 64-bit word, read and written over a simple memory port.

A map command fills in leaf entries. Where a middle or leaf table is missing, the block takes a fresh region from an internal bump allocator, clears the region word by word, and links it into the parent entry. An unmap command only drops the valid bit of leaves that are present. At the end of a command the block pulses done. It then reports two results: whether the command failed, and whether any entry was rewritten in a way that requires cached translations to be flushed.

The root table base, the allocator's start address (loaded at reset) and the allocator's limit are inputs that stay static while a command runs.

Top module: `aux_range_prog`

## Requirements
- R1: A command covers ceil(size / 64 KB) chunks. At each chunk the main address advances by 64 KB and the aux address by 256 bytes. A zero size finishes with no memory access.
- R2: A command is rejected if the main address has any of bits 15:0 set, or if it is a map and either the aux address has any of bits 7:0 set or the bpp value is unsupported. A rejected command raises done with the error flag in the cycle after it is accepted, and it makes no memory access.
- R3: Root entries are indexed by main bits 47:36 at root_base + 8*index. When a map finds a root entry with bit 0 clear, it takes a 32 KB region aligned to 32 KB from the allocator, writes 4096 zero words into it, and then writes base|1 into the root entry.
- R4: Middle entries are indexed by main bits 35:24. When a map finds a middle entry with bit 0 clear, it takes an 8 KB region aligned to 8 KB, writes 1024 zero words into it, and then writes base|1 into the middle entry. Leaf entries are indexed by main bits 23:16.
- R5: A leaf written by a map holds the format code in bits 63:58, the depth code in bits 56:54, the value 01 in bits 53:52, aux address bits 47:8 in bits 47:8, and 1 in bit 0. All other bits are 0.
- R6: The depth codes are: bpp 16→0, 10→1, 12→2, 8→4, 32→5, 64→6, 128→7.
- R7: A map that finds a leaf with bit 0 already set leaves that leaf unchanged.
- R8: A map onto a leaf with bit 0 clear sets the flush flag if the old word is non-zero and differs from the new leaf once the old word's bit 0 is forced to 1.
- R9: An unmap clears only bit 0 of a valid leaf. It skips a chunk whose root, middle or leaf entry is invalid, and it never allocates.
- R10: An unmap sets the flush flag if the leaf becomes all zero.
- R11: The allocator pointer starts at alloc_base and advances past every region it hands out. If a region's end would exceed alloc_limit, the command stops with the error flag, writes nothing, and leaves the pointer where it was.
- R12: done is a one-cycle pulse. cmd_err and flush_needed (the OR over the command) hold until the next command is accepted. cmd_ready is high only while the block is idle, and no memory access occurs while it is idle.
- R13: Read data returns on mem_rdata in the cycle after the request. Every access is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 48 | Base of the 32 KB root table |
| alloc_base | input | 48 | Allocator start address, loaded during reset |
| alloc_limit | input | 48 | Highest end address a new table may reach |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_unmap | input | 1 | 1 = unmap, 0 = map |
| cmd_main_addr | input | 48 | First main-surface address |
| cmd_size | input | 48 | Range length in bytes |
| cmd_aux_addr | input | 48 | First aux-data address |
| cmd_format | input | 6 | Format code placed in the leaf |
| cmd_bpp | input | 8 | Bits per pixel |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Last command rejected or out of space |
| flush_needed | output | 1 | Last command requires a flush |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address of a 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |

## Verification
Every cycle, the assertions check a fixed set of rules. Accesses are word-aligned. Writes stay inside the root table or below the allocator limit. The port is silent while the block is idle. done is a single pulse. The result flags stay steady between commands. A misaligned main address is rejected at once. What the bench's scenarios show instead is the content of the tables: where new regions land after alignment padding, the number of zero words, the exact leaf layout for each depth code, and the flush decisions for stale, cleared and already-valid leaves. These scenarios also show that a failed allocation leaves the pointer untouched.

// File: rtl/aux_tbl_pkg.sv
package aux_tbl_pkg;
    localparam int AW          = 48;
    localparam int EW          = 64;
    localparam int CHUNK_LG    = 16;
    localparam int AUX_STEP_LG = 8;
    localparam int MID_TBL_LG  = 15;
    localparam int LEAF_TBL_LG = 13;
    localparam int ROOT_IDX_LSB = 36;
    localparam int MID_IDX_LSB  = 24;
    localparam int LEAF_IDX_LSB = 16;
    localparam int ROOT_IDX_W   = 12;
    localparam int MID_IDX_W    = 12;
    localparam int LEAF_IDX_W   = 8;
    localparam int FMT_LSB   = 58;
    localparam int DEPTH_LSB = 54;
    localparam int TILE_LSB  = 52;
    localparam int ZCNT_W    = MID_TBL_LG - 3;

    typedef enum logic [3:0] {
        S_IDLE, S_RD3, S_CK3, S_RD2, S_CK2, S_RD1, S_CK1,
        S_ZERO, S_LINK, S_WLEAF, S_STEP, S_FIN
    } state_e;

    typedef struct packed {
        state_e            st;
        logic [AW-1:0]     main_a;
        logic [AW-1:0]     aux_a;
        logic [AW-1:0]     off;
        logic [AW-1:0]     size;
        logic [AW-1:0]     tbl;
        logic [AW-1:0]     ent;
        logic [AW-1:0]     ptr;
        logic              unmap;
        logic [5:0]        fmt;
        logic [2:0]        dcode;
        logic [ZCNT_W-1:0] zcnt;
        logic [ZCNT_W-1:0] zlast;
        logic              link_root;
        logic [EW-1:0]     wleaf;
        logic              flush;
        logic              err;
    } ctl_s;
endpackage

// File: rtl/aux_depth_code.sv
module aux_depth_code (
    input  logic [7:0] bpp,
    output logic [2:0] code,
    output logic       ok
);
    always_comb begin
        ok   = 1'b1;
        code = 3'd0;
        case (bpp)
            8'd16:  code = 3'd0;
            8'd10:  code = 3'd1;
            8'd12:  code = 3'd2;
            8'd8:   code = 3'd4;
            8'd32:  code = 3'd5;
            8'd64:  code = 3'd6;
            8'd128: code = 3'd7;
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/aux_bump_fit.sv
module aux_bump_fit #(
    parameter int AW     = 48,
    parameter int BIG_LG = 15,
    parameter int SML_LG = 13
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] limit,
    input  logic          big,
    output logic [AW-1:0] base,
    output logic [AW-1:0] next,
    output logic          ok
);
    localparam logic [AW:0] BIG_MASK = (AW+1)'((64'd1 << BIG_LG) - 64'd1);
    localparam logic [AW:0] SML_MASK = (AW+1)'((64'd1 << SML_LG) - 64'd1);

    logic [AW:0] mask, b, n;

    always_comb begin
        mask = big ? BIG_MASK : SML_MASK;
        b    = ({1'b0, ptr} + mask) & ~mask;
        n    = b + mask + (AW+1)'(1);
        ok   = (n <= {1'b0, limit});
        base = b[AW-1:0];
        next = n[AW-1:0];
    end
endmodule

// File: rtl/aux_range_prog.sv
module aux_range_prog
    import aux_tbl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [47:0]   root_base,
    input  logic [47:0]   alloc_base,
    input  logic [47:0]   alloc_limit,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_unmap,
    input  logic [47:0]   cmd_main_addr,
    input  logic [47:0]   cmd_size,
    input  logic [47:0]   cmd_aux_addr,
    input  logic [5:0]    cmd_format,
    input  logic [7:0]    cmd_bpp,
    output logic          done,
    output logic          cmd_err,
    output logic          flush_needed,
    output logic          mem_req,
    output logic          mem_we,
    output logic [47:0]   mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata
);
    localparam logic [AW:0]       CHUNK     = (AW+1)'(64'd1 << CHUNK_LG);
    localparam logic [ZCNT_W-1:0] MID_LAST  = ZCNT_W'((64'd1 << (MID_TBL_LG - 3)) - 64'd1);
    localparam logic [ZCNT_W-1:0] LEAF_LAST = ZCNT_W'((64'd1 << (LEAF_TBL_LG - 3)) - 64'd1);
    localparam logic [EW-1:0]     AUX_MASK  = EW'(((64'd1 << AW) - 64'd1) & ~((64'd1 << AUX_STEP_LG) - 64'd1));

    ctl_s q, d;

    logic [2:0]    cmd_dcode;
    logic          cmd_dok;
    logic          fit_big, fit_ok;
    logic [AW-1:0] fit_base, fit_next;
    logic [EW-1:0] leaf_v;
    logic [AW-1:0] acc_a;

    aux_depth_code u_depth (
        .bpp  (cmd_bpp),
        .code (cmd_dcode),
        .ok   (cmd_dok)
    );

    aux_bump_fit #(.AW(AW), .BIG_LG(MID_TBL_LG), .SML_LG(LEAF_TBL_LG)) u_fit (
        .ptr   (q.ptr),
        .limit (alloc_limit),
        .big   (fit_big),
        .base  (fit_base),
        .next  (fit_next),
        .ok    (fit_ok)
    );

    always_comb begin
        leaf_v = (EW'(q.fmt) << FMT_LSB) | (EW'(q.dcode) << DEPTH_LSB)
               | (EW'(2'b01) << TILE_LSB) | (EW'(q.aux_a) & AUX_MASK) | EW'(1);
    end

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fit_big   = 1'b0;
        acc_a     = '0;
        case (q.st)
            S_IDLE: if (cmd_valid) begin
                d.flush  = 1'b0;
                d.err    = 1'b0;
                d.main_a = cmd_main_addr;
                d.aux_a  = cmd_aux_addr;
                d.size   = cmd_size;
                d.off    = '0;
                d.unmap  = cmd_unmap;
                d.fmt    = cmd_format;
                d.dcode  = cmd_dcode;
                if (cmd_main_addr[CHUNK_LG-1:0] != '0 ||
                    (!cmd_unmap && (cmd_aux_addr[AUX_STEP_LG-1:0] != '0 || !cmd_dok))) begin
                    d.err = 1'b1;
                    d.st  = S_FIN;
                end else if (cmd_size == '0) begin
                    d.st = S_FIN;
                end else begin
                    d.st = S_RD3;
                end
            end
            S_RD3: begin
                acc_a   = root_base + AW'({q.main_a[ROOT_IDX_LSB +: ROOT_IDX_W], 3'b000});
                mem_req = 1'b1;
                mem_addr = acc_a;
                d.ent   = acc_a;
                d.st    = S_CK3;
            end
            S_CK3: begin
                if (mem_rdata[0]) begin
                    d.tbl = {mem_rdata[AW-1:MID_TBL_LG], {MID_TBL_LG{1'b0}}};
                    d.st  = S_RD2;
                end else if (q.unmap) begin
                    d.st = S_STEP;
                end else begin
                    fit_big = 1'b1;
                    if (!fit_ok) begin
                        d.err = 1'b1;
                        d.st  = S_FIN;
                    end else begin
                        d.tbl       = fit_base;
                        d.ptr       = fit_next;
                        d.zcnt      = '0;
                        d.zlast     = MID_LAST;
                        d.link_root = 1'b1;
                        d.st        = S_ZERO;
                    end
                end
            end
            S_RD2: begin
                acc_a    = q.tbl + AW'({q.main_a[MID_IDX_LSB +: MID_IDX_W], 3'b000});
                mem_req  = 1'b1;
                mem_addr = acc_a;
                d.ent    = acc_a;
                d.st     = S_CK2;
            end
            S_CK2: begin
                if (mem_rdata[0]) begin
                    d.tbl = {mem_rdata[AW-1:LEAF_TBL_LG], {LEAF_TBL_LG{1'b0}}};
                    d.st  = S_RD1;
                end else if (q.unmap) begin
                    d.st = S_STEP;
                end else begin
                    fit_big = 1'b0;
                    if (!fit_ok) begin
                        d.err = 1'b1;
                        d.st  = S_FIN;
                    end else begin
                        d.tbl       = fit_base;
                        d.ptr       = fit_next;
                        d.zcnt      = '0;
                        d.zlast     = LEAF_LAST;
                        d.link_root = 1'b0;
                        d.st        = S_ZERO;
                    end
                end
            end
            S_ZERO: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.tbl + AW'({q.zcnt, 3'b000});
                d.zcnt   = q.zcnt + ZCNT_W'(1);
                if (q.zcnt == q.zlast) d.st = S_LINK;
            end
            S_LINK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ent;
                mem_wdata = EW'(q.tbl) | EW'(1);
                d.st      = q.link_root ? S_RD2 : S_RD1;
            end
            S_RD1: begin
                acc_a    = q.tbl + AW'({q.main_a[LEAF_IDX_LSB +: LEAF_IDX_W], 3'b000});
                mem_req  = 1'b1;
                mem_addr = acc_a;
                d.ent    = acc_a;
                d.st     = S_CK1;
            end
            S_CK1: begin
                if (!mem_rdata[0] && q.unmap) begin
                    d.st = S_STEP;
                end else if (q.unmap) begin
                    d.wleaf = mem_rdata & ~EW'(1);
                    if ((mem_rdata & ~EW'(1)) == '0) d.flush = 1'b1;
                    d.st = S_WLEAF;
                end else if (mem_rdata[0]) begin
                    d.st = S_STEP;
                end else begin
                    d.wleaf = leaf_v;
                    if (mem_rdata != '0 && (mem_rdata | EW'(1)) != leaf_v) d.flush = 1'b1;
                    d.st = S_WLEAF;
                end
            end
            S_WLEAF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ent;
                mem_wdata = q.wleaf;
                d.st      = S_STEP;
            end
            S_STEP: begin
                d.main_a = q.main_a + AW'(CHUNK);
                d.aux_a  = q.aux_a + AW'(64'd1 << AUX_STEP_LG);
                d.off    = q.off + AW'(CHUNK);
                d.st     = (({1'b0, q.off} + CHUNK) < {1'b0, q.size}) ? S_RD3 : S_FIN;
            end
            S_FIN:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.ptr <= alloc_base;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready    = (q.st == S_IDLE);
    assign done         = (q.st == S_FIN);
    assign cmd_err      = q.err;
    assign flush_needed = q.flush;
endmodule

// File: rtl/aux_range_prog_chk.sv
module aux_range_prog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [47:0] root_base,
    input logic [47:0] alloc_limit,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [47:0] cmd_main_addr,
    input logic        done,
    input logic        cmd_err,
    input logic        flush_needed,
    input logic        mem_req,
    input logic        mem_we,
    input logic [47:0] mem_addr
);
    a_r13_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    a_r12_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> ($stable(flush_needed) && $stable(cmd_err)));

    a_r2_reject_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_main_addr[15:0] != 16'h0) |=> (done && cmd_err && !mem_req));

    a_r11_write_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            ((mem_addr >= root_base && mem_addr < root_base + 48'h8000) || mem_addr < alloc_limit));
endmodule

bind aux_range_prog aux_range_prog_chk u_chk (.*);

// File: tb/aux_range_prog_test.sv
module aux_range_prog_test;
    localparam logic [47:0] ROOT   = 48'h0000_1000_0000;
    localparam logic [47:0] ALLOC0 = 48'h0000_2000_0100;
    localparam logic [47:0] BIGLIM = 48'h0000_4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] alloc_limit = BIGLIM;
    logic        cmd_valid = 1'b0, cmd_unmap = 1'b0;
    logic [47:0] cmd_main_addr = '0, cmd_size = '0, cmd_aux_addr = '0;
    logic [5:0]  cmd_format = '0;
    logic [7:0]  cmd_bpp = 8'd32;
    logic        cmd_ready, done, cmd_err, flush_needed;
    logic        mem_req, mem_we;
    logic [47:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, zero_cnt = 0, acc_cnt = 0;
    logic [63:0] mem [logic [47:0]];

    always #5 clk = ~clk;

    aux_range_prog uut (
        .clk(clk), .rst_n(rst_n), .root_base(ROOT), .alloc_base(ALLOC0),
        .alloc_limit(alloc_limit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_unmap(cmd_unmap), .cmd_main_addr(cmd_main_addr), .cmd_size(cmd_size),
        .cmd_aux_addr(cmd_aux_addr), .cmd_format(cmd_format), .cmd_bpp(cmd_bpp),
        .done(done), .cmd_err(cmd_err), .flush_needed(flush_needed),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] rd(input logic [47:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] leaf(input logic [47:0] aux, input logic [5:0] f, input logic [2:0] dc);
        return {f, 1'b0, dc, 2'b01, 4'b0000, aux[47:8], 7'b0000000, 1'b1};
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            acc_cnt = acc_cnt + 1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt = wr_cnt + 1;
                if (mem_wdata == 64'h0) zero_cnt = zero_cnt + 1;
            end else begin
                mem_rdata <= rd(mem_addr);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit um, input logic [47:0] ma, input logic [47:0] sz,
                           input logic [47:0] aa, input logic [5:0] f, input logic [7:0] b);
        int t = 0;
        @(negedge clk);
        wr_cnt = 0; zero_cnt = 0; acc_cnt = 0;
        cmd_unmap = um; cmd_main_addr = ma; cmd_size = sz;
        cmd_aux_addr = aa; cmd_format = f; cmd_bpp = b; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check(1'b0, "R12 done timeout", 64'(t), 64'd20000);
        @(negedge clk);
        check(!done && cmd_ready, "R12 done single pulse", {62'b0, done, cmd_ready}, 64'h1);
    endtask

    task automatic t_reset;
        check(cmd_ready == 1'b1, "R12 reset ready", 64'(cmd_ready), 64'h1);
        check(!done && !cmd_err && !flush_needed, "R12 reset flags",
              {61'b0, done, cmd_err, flush_needed}, 64'h0);
        check(acc_cnt == 0, "R12 idle no access", 64'(acc_cnt), 64'h0);
    endtask

    task automatic t_first_map;
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h20000, 48'h0000_5000_0100, 6'h0A, 8'd32);
        check(cmd_err == 1'b0, "R3 no error", 64'(cmd_err), 64'h0);
        check(rd(ROOT + 48'h8) == 64'h2000_8001, "R3 root entry", rd(ROOT + 48'h8), 64'h2000_8001);
        check(zero_cnt == 5120, "R3 R4 zero words", 64'(zero_cnt), 64'd5120);
        check(rd(48'h2000_91A0) == 64'h2001_0001, "R4 middle entry", rd(48'h2000_91A0), 64'h2001_0001);
        check(rd(48'h2001_02B0) == leaf(48'h5000_0100, 6'h0A, 3'd5), "R5 leaf 0",
              rd(48'h2001_02B0), leaf(48'h5000_0100, 6'h0A, 3'd5));
        check(rd(48'h2001_02B8) == leaf(48'h5000_0200, 6'h0A, 3'd5), "R1 second chunk aux step",
              rd(48'h2001_02B8), leaf(48'h5000_0200, 6'h0A, 3'd5));
        check(wr_cnt == 5124, "R1 write count", 64'(wr_cnt), 64'd5124);
        check(flush_needed == 1'b0, "R8 fresh map no flush", 64'(flush_needed), 64'h0);
    endtask

    task automatic t_remap_valid;
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h20000, 48'h0000_6000_0000, 6'h0A, 8'd32);
        check(wr_cnt == 0, "R7 valid leaf untouched", 64'(wr_cnt), 64'h0);
        check(rd(48'h2001_02B0) == leaf(48'h5000_0100, 6'h0A, 3'd5), "R7 leaf kept",
              rd(48'h2001_02B0), leaf(48'h5000_0100, 6'h0A, 3'd5));
        check(flush_needed == 1'b0, "R7 no flush", 64'(flush_needed), 64'h0);
    endtask

    task automatic t_unmap_and_stale;
        logic [63:0] e;
        run_cmd(1'b1, 48'h0012_3456_0000, 48'h20000, 48'h0, 6'h0, 8'd0);
        e = leaf(48'h5000_0200, 6'h0A, 3'd5) & ~64'h1;
        check(rd(48'h2001_02B8) == e, "R9 unmap clears bit 0 only", rd(48'h2001_02B8), e);
        check(wr_cnt == 2 && !flush_needed, "R9 unmap two writes no flush", 64'(wr_cnt), 64'd2);
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h20000, 48'h0000_6000_0000, 6'h0A, 8'd32);
        check(flush_needed == 1'b1, "R8 stale differing leaf flushes", 64'(flush_needed), 64'h1);
        check(rd(48'h2001_02B0) == leaf(48'h6000_0000, 6'h0A, 3'd5), "R8 new leaf written",
              rd(48'h2001_02B0), leaf(48'h6000_0000, 6'h0A, 3'd5));
        repeat (5) @(negedge clk);
        check(flush_needed == 1'b1, "R12 flush held while idle", 64'(flush_needed), 64'h1);
        run_cmd(1'b1, 48'h0012_3456_0000, 48'h20000, 48'h0, 6'h0, 8'd0);
        check(flush_needed == 1'b0, "R12 flush cleared on accept", 64'(flush_needed), 64'h0);
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h20000, 48'h0000_6000_0000, 6'h0A, 8'd32);
        check(flush_needed == 1'b0, "R8 stale matching leaf no flush", 64'(flush_needed), 64'h0);
    endtask

    task automatic t_unmap_skips;
        run_cmd(1'b1, 48'h0050_0000_0000, 48'h10000, 48'h0, 6'h0, 8'd0);
        check(wr_cnt == 0 && !flush_needed && !cmd_err, "R9 invalid root skipped", 64'(wr_cnt), 64'h0);
        run_cmd(1'b1, 48'h0012_0000_0000, 48'h10000, 48'h0, 6'h0, 8'd0);
        check(wr_cnt == 0, "R9 invalid middle skipped", 64'(wr_cnt), 64'h0);
        mem[48'h2001_0080] = 64'h1;
        run_cmd(1'b1, 48'h0012_3410_0000, 48'h10000, 48'h0, 6'h0, 8'd0);
        check(rd(48'h2001_0080) == 64'h0, "R10 leaf cleared", rd(48'h2001_0080), 64'h0);
        check(flush_needed == 1'b1, "R10 zero leaf flushes", 64'(flush_needed), 64'h1);
    endtask

    task automatic t_depth_codes;
        logic [7:0] bv [7] = '{8'd16, 8'd10, 8'd12, 8'd8, 8'd32, 8'd64, 8'd128};
        logic [2:0] cv [7] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
        for (int k = 0; k < 7; k++) begin
            logic [47:0] la, aa;
            la = 48'h2001_0000 + 48'((8'h60 + k) * 8);
            aa = 48'h7000_0000 + 48'(k * 256);
            run_cmd(1'b0, 48'h0012_3460_0000 + 48'(k) * 48'h10000, 48'h1, aa, 6'h11, bv[k]);
            check(rd(la) == leaf(aa, 6'h11, cv[k]), "R6 depth code", rd(la), leaf(aa, 6'h11, cv[k]));
            check(wr_cnt == 1, "R1 one chunk for size 1", 64'(wr_cnt), 64'h1);
        end
    endtask

    task automatic t_rejects;
        run_cmd(1'b0, 48'h0012_3456_8000, 48'h10000, 48'h5000_0000, 6'h0A, 8'd32);
        check(cmd_err && acc_cnt == 0, "R2 misaligned main", 64'(acc_cnt), 64'h0);
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h10000, 48'h5000_0010, 6'h0A, 8'd32);
        check(cmd_err && acc_cnt == 0, "R2 misaligned aux", 64'(acc_cnt), 64'h0);
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h10000, 48'h5000_0000, 6'h0A, 8'd24);
        check(cmd_err && acc_cnt == 0, "R2 R6 unsupported bpp", 64'(acc_cnt), 64'h0);
        run_cmd(1'b0, 48'h0012_3456_0000, 48'h0, 48'h5000_0000, 6'h0A, 8'd32);
        check(!cmd_err && acc_cnt == 0, "R1 zero size", 64'(acc_cnt), 64'h0);
    endtask

    task automatic t_out_of_space;
        alloc_limit = 48'h2001_F000;
        run_cmd(1'b0, 48'h0020_0000_0000, 48'h10000, 48'h8000_0000, 6'h0A, 8'd32);
        check(cmd_err == 1'b1 && wr_cnt == 0, "R11 out of space", 64'(wr_cnt), 64'h0);
        alloc_limit = BIGLIM;
        run_cmd(1'b0, 48'h0020_0000_0000, 48'h10000, 48'h8000_0000, 6'h0A, 8'd32);
        check(!cmd_err, "R11 retry succeeds", 64'(cmd_err), 64'h0);
        check(rd(ROOT + 48'h10) == 64'h2001_8001, "R11 pointer unchanged by failure",
              rd(ROOT + 48'h10), 64'h2001_8001);
        check(rd(48'h2001_8000) == 64'h2002_0001, "R4 aligned middle link",
              rd(48'h2001_8000), 64'h2002_0001);
        check(rd(48'h2002_0000) == leaf(48'h8000_0000, 6'h0A, 3'd5), "R5 leaf new table",
              rd(48'h2002_0000), leaf(48'h8000_0000, 6'h0A, 3'd5));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_map();
        t_remap_valid();
        t_unmap_and_stale();
        t_unmap_skips();
        t_depth_codes();
        t_rejects();
        t_out_of_space();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule